// File: doc/BRIEF.md
# Queue Controller Enable and Status Register File

This block is the memory-mapped control register file that sits in front of a storage queue controller. Host software programs the admin queue depths and base addresses, the interrupt mask and a configuration word. When the enable field of the configuration word turns on, the block checks the admin queue settings against the advertised capabilities. It then reports either ready or a fatal error in the status word. When the enable field turns off, or a shutdown is requested, it tells the queue engines to tear down. Shutdown is acknowledged at once.

The interrupt mask is one 32-bit value with two write views: one sets the written bits and one clears them. Reads return the stored register bytes, little-endian, one cycle after the request. The block drives the derived page size, the entry size exponents, the admin queue depths and bases, and one-cycle init and clear strobes to the queue engines.

Top module: `qctl_regfile`

## Requirements
- R1: After reset the status, configuration, queue attribute, base and mask registers read zero. The version word at offset 0x08 reads 0x00010001. The 64-bit capability word at offset 0x00 reads 0x0040_0020_0F03_07FF, which holds these fields: max entries 0x7FF in bits 15:0, contiguous-required bit 16, arbitration bit 17, timeout 0xF in bits 31:24, command set bit 37, minimum page field 0 in bits 51:48, maximum page field 4 in bits 55:52.
- R2: A write to offset 0x0C ORs the low 32 data bits into the interrupt mask. Offsets 0x0C and 0x10 both read back the mask, which is also driven on `irq_mask`.
- R3: A write to offset 0x10 clears the mask bits that are set in the low 32 data bits.
- R4: The configuration word is at offset 0x14. Its fields are: enable bit 0, page field bits 10:7, shutdown request bits 15:14, submission entry exponent bits 19:16 and completion entry exponent bits 23:20. When a write turns enable from 0 to 1 with valid settings, the status word at 0x1C becomes 0x1 (ready, bit 0). `queues_init` pulses for one cycle. The outputs then show a page shift of page field + 12, the two entry exponents, and the admin depths of size field + 1.
- R5: If the settings on a 0-to-1 enable edge are invalid, the status becomes 0x2 (fatal, bit 1) and there is no init pulse. The settings are invalid when any of these holds: a base address is zero or not page-aligned; an admin size field is 0 or above 4095; the page field is outside 0..4; the completion exponent is not 4; the submission exponent is not 6. The fatal bit stays set until the next enable edge.
- R6: A write that turns enable from 1 to 0 clears the ready bit and pulses `queues_clear` for one cycle.
- R7: A configuration write that keeps enable at 1 starts no validation. It leaves the status, the derived outputs and `queues_init` unchanged.
- R8: When the shutdown request field changes from zero to nonzero, status bits 3:2 become 2'b10 and `queues_clear` pulses. When the field returns to zero, those status bits clear.
- R9: The admin attribute register is at 0x24, holding the submission size in bits 15:0 and the completion size in bits 31:16. The submission base is at 0x28 and the completion base at 0x30. A write to a base's low offset replaces the whole 64-bit value with the data. A write to its high offset (0x2C or 0x34) replaces only bits 63:32 with the low 32 data bits.
- R10: A read with size code 1, 2 or 3 returns 2, 4 or 8 bytes of the register image, little-endian from the given byte offset. It is returned on `rd_data` with `rd_valid` one cycle later. Bytes past offset 0x37 read as zero.
- R11: Writes to the capability, version and status offsets are ignored.
- R12: The page alignment check uses the page size from the written page field. With a page field of 1, a base of 0x21000 fails and a base of 0x22000 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_wr | input | 1 | Write request |
| acc_rd | input | 1 | Read request |
| acc_addr | input | ADDR_W | Byte offset |
| acc_size | input | 2 | Access size code: 1=2, 2=4, 3=8 bytes; 0 means no access |
| acc_wdata | input | 64 | Write data, little-endian |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| irq_mask | output | 32 | Interrupt mask |
| page_shift | output | 5 | Log2 of the page size |
| sq_ent_shift | output | 4 | Submission entry size exponent |
| cq_ent_shift | output | 4 | Completion entry size exponent |
| asq_base | output | 64 | Admin submission queue base |
| acq_base | output | 64 | Admin completion queue base |
| asq_depth | output | 17 | Admin submission queue depth |
| acq_depth | output | 17 | Admin completion queue depth |
| queues_init | output | 1 | One-cycle strobe after a successful enable |
| queues_clear | output | 1 | One-cycle strobe on disable or shutdown request |

## Verification
Every write takes effect at the clock edge that samples it. Register contents, status, derived outputs and both strobes are therefore due in the cycle right after that edge. The write task samples the strobes at the falling edge that follows and checks them there. Read data is due one cycle after the request edge. The read task pushes its expected word into a queue when it raises the request. A monitor pops that word at the falling edge where `rd_valid` is high, so each result is compared in the single cycle it is due.

// File: rtl/qctl_pkg.sv
package qctl_pkg;

    // byte offsets in the register image
    localparam int OFF_CAP    = 'h00;
    localparam int OFF_VER    = 'h08;
    localparam int OFF_MSET   = 'h0C;
    localparam int OFF_MCLR   = 'h10;
    localparam int OFF_CFG    = 'h14;
    localparam int OFF_STAT   = 'h1C;
    localparam int OFF_AQA    = 'h24;
    localparam int OFF_ASQ_LO = 'h28;
    localparam int OFF_ASQ_HI = 'h2C;
    localparam int OFF_ACQ_LO = 'h30;
    localparam int OFF_ACQ_HI = 'h34;
    localparam int IMG_USED   = 'h38;

    // configuration word fields
    localparam int CFG_EN     = 0;
    localparam int CFG_MPS_LO = 7;
    localparam int CFG_SHN_LO = 14;
    localparam int CFG_SQE_LO = 16;
    localparam int CFG_CQE_LO = 20;

    // status word fields
    localparam int ST_RDY     = 0;
    localparam int ST_FATAL   = 1;
    localparam int ST_SHST_LO = 2;
    localparam logic [1:0] SHST_DONE = 2'b10;

    localparam logic [31:0] VERSION_WORD = 32'h0001_0001;

    typedef struct packed {
        logic [31:0] cfg;
        logic [31:0] status;
        logic [31:0] aqa;
        logic [63:0] asq;
        logic [63:0] acq;
        logic [4:0]  pg_shift;
        logic [3:0]  sq_shift;
        logic [3:0]  cq_shift;
        logic [16:0] sq_depth;
        logic [16:0] cq_depth;
        logic        init;
        logic        clr;
        logic        rvalid;
        logic [63:0] rdata;
    } ctl_state_t;

endpackage

// File: rtl/qctl_enable_check.sv
module qctl_enable_check #(
    parameter int PAGE_MIN    = 0,
    parameter int PAGE_MAX    = 4,
    parameter int SQE_MIN     = 6,
    parameter int SQE_MAX     = 6,
    parameter int CQE_MIN     = 4,
    parameter int CQE_MAX     = 4,
    parameter int QSIZE_LIMIT = 4095
) (
    input  logic [3:0]  mps,
    input  logic [3:0]  sqes,
    input  logic [3:0]  cqes,
    input  logic [15:0] sq_size,
    input  logic [15:0] cq_size,
    input  logic [63:0] asq,
    input  logic [63:0] acq,
    output logic        ok,
    output logic [4:0]  pg_shift
);
    localparam int PAGE_BASE_SHIFT = 12;

    logic [63:0] pmask;
    logic        bad_base, bad_page, bad_ent, bad_size;

    always_comb begin
        pg_shift = 5'(mps) + 5'(PAGE_BASE_SHIFT);
        pmask    = (64'd1 << pg_shift) - 64'd1;
        bad_base = (asq == 64'd0) || (acq == 64'd0) ||
                   ((asq & pmask) != 64'd0) || ((acq & pmask) != 64'd0);
        bad_page = (int'(mps) < PAGE_MIN) || (int'(mps) > PAGE_MAX);
        bad_ent  = (int'(sqes) < SQE_MIN) || (int'(sqes) > SQE_MAX) ||
                   (int'(cqes) < CQE_MIN) || (int'(cqes) > CQE_MAX);
        bad_size = (sq_size == 16'd0) || (cq_size == 16'd0) ||
                   (int'(sq_size) > QSIZE_LIMIT) || (int'(cq_size) > QSIZE_LIMIT);
        ok       = !(bad_base || bad_page || bad_ent || bad_size);
    end

endmodule

// File: rtl/qctl_irq_mask.sv
module qctl_irq_mask #(
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [MASK_W-1:0] bits,
    output logic [MASK_W-1:0] mask
);
    logic [MASK_W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (set_en) mask_d = mask_q | bits;
        else if (clr_en) mask_d = mask_q & ~bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;

    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((mask_q & $past(bits)) == $past(bits)));

    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((mask_q & $past(bits)) == '0));

endmodule

// File: rtl/qctl_read_mux.sv
module qctl_read_mux #(
    parameter int ADDR_W = 6
) (
    input  logic [8*(1<<ADDR_W)-1:0] image,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [1:0]               size,
    output logic [63:0]              data
);
    localparam int IMG_BYTES = 1 << ADDR_W;

    logic [3:0] nbytes;

    always_comb begin
        case (size)
            2'd1:    nbytes = 4'd2;
            2'd2:    nbytes = 4'd4;
            2'd3:    nbytes = 4'd8;
            default: nbytes = 4'd0;
        endcase
    end

    for (genvar b = 0; b < 8; b++) begin : g_lane
        logic [ADDR_W:0] idx;
        always_comb begin
            idx = {1'b0, addr} + (ADDR_W+1)'(b);
            if ((b < int'(nbytes)) && (int'(idx) < IMG_BYTES))
                data[8*b +: 8] = image[8*idx +: 8];
            else
                data[8*b +: 8] = 8'h00;
        end
    end

endmodule

// File: rtl/qctl_regfile.sv
module qctl_regfile
    import qctl_pkg::*;
#(
    parameter int          ADDR_W      = 6,
    parameter int          PAGE_MIN    = 0,
    parameter int          PAGE_MAX    = 4,
    parameter int          SQE_MIN     = 6,
    parameter int          SQE_MAX     = 6,
    parameter int          CQE_MIN     = 4,
    parameter int          CQE_MAX     = 4,
    parameter int          QSIZE_LIMIT = 4095,
    parameter logic [15:0] MAX_ENTRIES = 16'h07FF,
    parameter logic [7:0]  TIMEOUT     = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [63:0]       acc_wdata,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic [31:0]       irq_mask,
    output logic [4:0]        page_shift,
    output logic [3:0]        sq_ent_shift,
    output logic [3:0]        cq_ent_shift,
    output logic [63:0]       asq_base,
    output logic [63:0]       acq_base,
    output logic [16:0]       asq_depth,
    output logic [16:0]       acq_depth,
    output logic              queues_init,
    output logic              queues_clear
);
    localparam int IMG_BYTES = 1 << ADDR_W;
    localparam logic [63:0] CAP_WORD =
          64'(MAX_ENTRIES)
        | (64'd1 << 16)
        | (64'd1 << 17)
        | (64'(TIMEOUT) << 24)
        | (64'd1 << 37)
        | (64'(PAGE_MIN[3:0]) << 48)
        | (64'(PAGE_MAX[3:0]) << 52);

    ctl_state_t st_d, st_q;

    logic [63:0] wmask, wval;
    logic        wr_ok, wr_cfg;
    logic        chk_ok;
    logic [4:0]  chk_shift;
    logic [31:0] mask_val;
    logic [63:0] rd_lane;
    logic [8*IMG_BYTES-1:0] image;

    // write data shaped by access size
    always_comb begin
        case (acc_size)
            2'd1:    wmask = 64'h0000_0000_0000_FFFF;
            2'd2:    wmask = 64'h0000_0000_FFFF_FFFF;
            2'd3:    wmask = 64'hFFFF_FFFF_FFFF_FFFF;
            default: wmask = 64'd0;
        endcase
        wval   = acc_wdata & wmask;
        wr_ok  = acc_wr && (acc_size != 2'd0);
        wr_cfg = wr_ok && (acc_addr == ADDR_W'(OFF_CFG));
    end

    qctl_enable_check #(
        .PAGE_MIN(PAGE_MIN), .PAGE_MAX(PAGE_MAX),
        .SQE_MIN(SQE_MIN), .SQE_MAX(SQE_MAX),
        .CQE_MIN(CQE_MIN), .CQE_MAX(CQE_MAX),
        .QSIZE_LIMIT(QSIZE_LIMIT)
    ) u_check (
        .mps      (wval[CFG_MPS_LO +: 4]),
        .sqes     (wval[CFG_SQE_LO +: 4]),
        .cqes     (wval[CFG_CQE_LO +: 4]),
        .sq_size  (st_q.aqa[15:0]),
        .cq_size  (st_q.aqa[31:16]),
        .asq      (st_q.asq),
        .acq      (st_q.acq),
        .ok       (chk_ok),
        .pg_shift (chk_shift)
    );

    qctl_irq_mask #(.MASK_W(32)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_ok && (acc_addr == ADDR_W'(OFF_MSET))),
        .clr_en (wr_ok && (acc_addr == ADDR_W'(OFF_MCLR))),
        .bits   (wval[31:0]),
        .mask   (mask_val)
    );

    // byte image seen by reads
    always_comb begin
        image = '0;
        image[8*OFF_CAP  +: 64] = CAP_WORD;
        image[8*OFF_VER  +: 32] = VERSION_WORD;
        image[8*OFF_MSET +: 32] = mask_val;
        image[8*OFF_MCLR +: 32] = mask_val;
        image[8*OFF_CFG  +: 32] = st_q.cfg;
        image[8*OFF_STAT +: 32] = st_q.status;
        image[8*OFF_AQA  +: 32] = st_q.aqa;
        image[8*OFF_ASQ_LO +: 64] = st_q.asq;
        image[8*OFF_ACQ_LO +: 64] = st_q.acq;
    end

    qctl_read_mux #(.ADDR_W(ADDR_W)) u_rd (
        .image (image),
        .addr  (acc_addr),
        .size  (acc_size),
        .data  (rd_lane)
    );

    // next-state logic
    always_comb begin
        logic en_old, en_new, shn_old, shn_new;
        st_d        = st_q;
        st_d.init   = 1'b0;
        st_d.clr    = 1'b0;
        st_d.rvalid = acc_rd;
        if (acc_rd) st_d.rdata = rd_lane;

        en_old  = st_q.cfg[CFG_EN];
        en_new  = wval[CFG_EN];
        shn_old = |st_q.cfg[CFG_SHN_LO +: 2];
        shn_new = |wval[CFG_SHN_LO +: 2];

        if (wr_cfg) begin
            st_d.cfg = wval[31:0];
            if (en_new && !en_old) begin
                if (chk_ok) begin
                    st_d.status   = 32'd1 << ST_RDY;
                    st_d.init     = 1'b1;
                    st_d.pg_shift = chk_shift;
                    st_d.sq_shift = wval[CFG_SQE_LO +: 4];
                    st_d.cq_shift = wval[CFG_CQE_LO +: 4];
                    st_d.sq_depth = 17'(st_q.aqa[15:0]) + 17'd1;
                    st_d.cq_depth = 17'(st_q.aqa[31:16]) + 17'd1;
                end else begin
                    st_d.status   = 32'd1 << ST_FATAL;
                end
            end else if (!en_new && en_old) begin
                st_d.status[ST_RDY] = 1'b0;
                st_d.clr            = 1'b1;
            end
            if (shn_new && !shn_old) begin
                st_d.status[ST_SHST_LO +: 2] = SHST_DONE;
                st_d.clr                     = 1'b1;
            end else if (!shn_new && shn_old) begin
                st_d.status[ST_SHST_LO +: 2] = 2'b00;
            end
        end else if (wr_ok) begin
            case (acc_addr)
                ADDR_W'(OFF_AQA):    st_d.aqa        = wval[31:0];
                ADDR_W'(OFF_ASQ_LO): st_d.asq        = wval;
                ADDR_W'(OFF_ASQ_HI): st_d.asq[63:32] = wval[31:0];
                ADDR_W'(OFF_ACQ_LO): st_d.acq        = wval;
                ADDR_W'(OFF_ACQ_HI): st_d.acq[63:32] = wval[31:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid     = st_q.rvalid;
    assign rd_data      = st_q.rdata;
    assign irq_mask     = mask_val;
    assign page_shift   = st_q.pg_shift;
    assign sq_ent_shift = st_q.sq_shift;
    assign cq_ent_shift = st_q.cq_shift;
    assign asq_base     = st_q.asq;
    assign acq_base     = st_q.acq;
    assign asq_depth    = st_q.sq_depth;
    assign acq_depth    = st_q.cq_depth;
    assign queues_init  = st_q.init;
    assign queues_clear = st_q.clr;

    a_r4_init_means_ready: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.init |-> st_q.status[ST_RDY]);

    a_r4_init_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.init |=> !st_q.init);

    a_r5_ready_fatal_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.status[ST_RDY] && st_q.status[ST_FATAL]));

    a_r6_clear_unready: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.clr && !st_q.cfg[CFG_EN]) |-> !st_q.status[ST_RDY]);

    a_r7_no_revalidate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && st_q.cfg[CFG_EN] && wval[CFG_EN])
            |=> (!st_q.init && $stable(st_q.pg_shift)));

    a_r10_read_due: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd_valid);

    a_r10_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !rd_valid);

endmodule

// File: tb/tb_qctl_regfile.sv
module tb_qctl_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic [5:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [63:0] acc_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [31:0] irq_mask;
    logic [4:0]  page_shift;
    logic [3:0]  sq_ent_shift, cq_ent_shift;
    logic [63:0] asq_base, acq_base;
    logic [16:0] asq_depth, acq_depth;
    logic        queues_init, queues_clear;

    int checks = 0;
    int fails  = 0;
    logic saw_init, saw_clr;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    localparam logic [63:0] CAP_EXP = 64'h0040_0020_0F03_07FF;
    localparam logic [31:0] CFG_OK  = 32'h0046_0001;

    always #5 clk = ~clk;

    qctl_regfile dut (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_mask(irq_mask),
        .page_shift(page_shift), .sq_ent_shift(sq_ent_shift),
        .cq_ent_shift(cq_ent_shift), .asq_base(asq_base), .acq_base(acq_base),
        .asq_depth(asq_depth), .acq_depth(acq_depth),
        .queues_init(queues_init), .queues_clear(queues_clear)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [1:0] sz, input logic [63:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
        saw_init = queues_init;
        saw_clr  = queues_clear;
    endtask

    task automatic rd(input logic [5:0] a, input logic [1:0] sz,
                      input logic [63:0] exp, input string tag);
        @(negedge clk);
        acc_rd = 1'b1; acc_addr = a; acc_size = sz;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        acc_rd = 1'b0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R10 unexpected read data actual=%h expected=none", rd_data);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, rd_data, e);
                end
            end
        end
    end

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    task automatic en_expect_fatal(input logic [31:0] cfg, input string tag);
        wr(6'h14, 2'd2, 64'(cfg));
        check({tag, " no init"}, 64'(saw_init), 64'd0);
        rd(6'h1C, 2'd2, 64'h2, {tag, " fatal status"});
        wr(6'h14, 2'd2, 64'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq_mask", 64'(irq_mask), 64'd0);
        check("R1 init", 64'(queues_init), 64'd0);
        check("R1 rd_valid", 64'(rd_valid), 64'd0);
        rd(6'h00, 2'd3, CAP_EXP, "R1 capability");
        rd(6'h08, 2'd2, 64'h0001_0001, "R1 version");
        rd(6'h1C, 2'd2, 64'h0, "R1 status");
        rd(6'h14, 2'd2, 64'h0, "R1 config");
        rd(6'h0A, 2'd1, 64'h0001, "R10 two-byte read");

        // R11 read-only offsets
        wr(6'h08, 2'd2, 64'hDEAD_BEEF);
        rd(6'h08, 2'd2, 64'h0001_0001, "R11 version kept");
        wr(6'h00, 2'd3, 64'h1234_5678_9ABC_DEF0);
        rd(6'h00, 2'd3, CAP_EXP, "R11 capability kept");
        wr(6'h1C, 2'd2, 64'hF);
        rd(6'h1C, 2'd2, 64'h0, "R11 status kept");

        // R2 / R3 mask
        wr(6'h0C, 2'd2, 64'h0000_00F0);
        wr(6'h0C, 2'd2, 64'h0000_0F00);
        check("R2 mask or", 64'(irq_mask), 64'h0FF0);
        rd(6'h0C, 2'd2, 64'h0FF0, "R2 set view");
        rd(6'h10, 2'd2, 64'h0FF0, "R2 clear view");
        wr(6'h10, 2'd2, 64'h0000_0030);
        check("R3 mask clear", 64'(irq_mask), 64'h0FC0);

        // R9 base registers
        wr(6'h28, 2'd3, 64'h0000_0000_0001_0000);
        wr(6'h2C, 2'd2, 64'h0000_0001);
        rd(6'h28, 2'd3, 64'h0000_0001_0001_0000, "R9 high half");
        check("R9 asq port", asq_base, 64'h0000_0001_0001_0000);
        wr(6'h28, 2'd2, 64'h0001_0000);
        rd(6'h28, 2'd3, 64'h0000_0000_0001_0000, "R9 low replaces");
        wr(6'h30, 2'd2, 64'h0002_0000);
        wr(6'h24, 2'd2, 64'h003F_001F);

        // R4 good enable
        wr(6'h14, 2'd2, 64'(CFG_OK));
        check("R4 init pulse", 64'(saw_init), 64'd1);
        @(negedge clk);
        check("R4 init one cycle", 64'(queues_init), 64'd0);
        rd(6'h1C, 2'd2, 64'h1, "R4 ready");
        check("R4 page shift", 64'(page_shift), 64'd12);
        check("R4 sq shift", 64'(sq_ent_shift), 64'd6);
        check("R4 cq shift", 64'(cq_ent_shift), 64'd4);
        check("R4 sq depth", 64'(asq_depth), 64'd32);
        check("R4 cq depth", 64'(acq_depth), 64'd64);

        // R7 enable held
        wr(6'h14, 2'd2, 64'h0046_0081);
        check("R7 no init", 64'(saw_init), 64'd0);
        check("R7 page shift kept", 64'(page_shift), 64'd12);
        rd(6'h1C, 2'd2, 64'h1, "R7 status kept");

        // R8 shutdown
        wr(6'h14, 2'd2, 64'h0046_4081);
        check("R8 clear pulse", 64'(saw_clr), 64'd1);
        rd(6'h1C, 2'd2, 64'h9, "R8 shutdown done");
        wr(6'h14, 2'd2, 64'h0046_0081);
        check("R8 no pulse on release", 64'(saw_clr), 64'd0);
        rd(6'h1C, 2'd2, 64'h1, "R8 shutdown cleared");

        // R6 disable
        wr(6'h14, 2'd2, 64'h0046_0000);
        check("R6 clear pulse", 64'(saw_clr), 64'd1);
        rd(6'h1C, 2'd2, 64'h0, "R6 ready dropped");

        // R5 invalid settings
        en_expect_fatal(32'h0056_0001, "R5 cq exponent");
        rd(6'h1C, 2'd2, 64'h2, "R5 fatal sticky");
        en_expect_fatal(32'h0046_0281, "R5 page field high");
        wr(6'h24, 2'd2, 64'h003F_0000);
        en_expect_fatal(CFG_OK, "R5 sq size zero");
        wr(6'h24, 2'd2, 64'h1000_001F);
        en_expect_fatal(CFG_OK, "R5 cq size 4096");
        wr(6'h24, 2'd2, 64'h0FFF_001F);
        wr(6'h14, 2'd2, 64'(CFG_OK));
        check("R5 size 4095 ok", 64'(saw_init), 64'd1);
        check("R4 cq depth 4096", 64'(acq_depth), 64'd4096);
        wr(6'h14, 2'd2, 64'h0);
        wr(6'h28, 2'd3, 64'h0);
        en_expect_fatal(CFG_OK, "R5 base zero");
        wr(6'h28, 2'd3, 64'h0001_0000);

        // R12 page alignment follows page field
        wr(6'h30, 2'd3, 64'h0002_1000);
        en_expect_fatal(32'h0046_0081, "R12 8K misaligned");
        wr(6'h14, 2'd2, 64'(CFG_OK));
        check("R12 4K aligned ok", 64'(saw_init), 64'd1);
        wr(6'h14, 2'd2, 64'h0);
        wr(6'h30, 2'd3, 64'h0002_2000);
        wr(6'h14, 2'd2, 64'h0046_0081);
        check("R12 8K aligned ok", 64'(saw_init), 64'd1);
        check("R12 page shift", 64'(page_shift), 64'd13);

        // R10 read edges
        wr(6'h34, 2'd2, 64'hABCD_1234);
        rd(6'h34, 2'd2, 64'hABCD_1234, "R10 four-byte read");
        rd(6'h36, 2'd3, 64'h0000_ABCD, "R10 past end zero");
        rd(6'h3C, 2'd3, 64'h0, "R10 unused space");

        repeat (4) @(negedge clk);
        check("R10 all reads returned", 64'(exp_q.size()), 64'd0);
        summary();
    end

endmodule